// File: doc/BRIEF.md
# Receiver Error Logger with Sample Concealment

This block sits behind a digital audio interface decoder and watches the error flags the decoder raises with every received frame. Seven kinds of fault are tracked: lost clock lock, a set validity flag, poor decode confidence, a biphase coding violation, a parity failure, a Q-subcode CRC failure and a channel-status CRC failure. Each fault has an enable bit. An enabled fault is written into a sticky log that the host reads through a single read strobe. It also drives an error output for the following sample period and raises an interrupt.

The audio sample that arrives with the flags passes through a concealment stage. When an enabled fault that can corrupt audio is present, the sample is replaced according to the selected mode. The replacement is either the last good sample or zero. In the third mode the sample is left unchanged. The two CRC faults describe side-channel data, not audio, so they never cause concealment.

Top module: `rxerr_logger`

## Requirements
- R1: The error log bit positions are: bit 0 lock lost, bit 1 validity set, bit 2 low confidence, bit 3 biphase violation, bit 4 parity failure, bit 5 Q-subcode CRC failure, bit 6 channel-status CRC failure. After reset `rd_data`, `irq`, `err_pulse`, `out_vld` and `out_sample` are all zero.
- R2: A flag on `in_err` is taken only while `in_vld` is high. If its `err_en` bit is 1, the matching `rd_data` bit becomes 1 one cycle later. The bit stays at 1, whatever later frames carry, until a read clears it.
- R3: The bits of `rd_data` are valid in the cycle `rd_stb` is high. The strobe clears only the bits that were 1 in that cycle. An error logged in the same cycle as the strobe is 1 afterwards.
- R4: An `err_en` bit of 0 blocks that fault completely. The fault is not logged, does not drive `err_pulse`, does not raise `irq` and does not cause concealment.
- R5: `err_pulse` is updated one cycle after each `in_vld`. It is high when that frame carried at least one enabled fault, and it holds that value until the next frame is taken.
- R6: `irq` is high exactly while the log holds at least one set bit. It follows the log with no extra delay.
- R7: `out_vld` is `in_vld` delayed by one cycle. `out_sample` is updated on that same edge.
- R8: With `conceal_mode` = 2'b01 (hold), a frame carrying an enabled concealing fault (bits 0 to 4) outputs the most recent sample that had no enabled concealing fault. Before any such sample, it outputs zero.
- R9: With `conceal_mode` = 2'b10 (mute), such a frame outputs zero.
- R10: With `conceal_mode` = 2'b00 (pass) or 2'b11, the sample is output unchanged even when a fault is present.
- R11: Bits 5 and 6 never change the output sample, even when enabled. A frame that carries only those faults counts as a good sample for the hold value.
- R12: The hold value is updated only by frames without an enabled concealing fault. A concealed frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Frame strobe from the decoder, one cycle per frame |
| in_sample | input | SAMPLE_W | Audio sample of the frame |
| in_err | input | 7 | Fault flags of the frame |
| err_en | input | 7 | Per-fault enable, 1 = enabled |
| conceal_mode | input | 2 | 00 pass, 01 hold, 10 mute, 11 pass |
| rd_stb | input | 1 | Read strobe, clears the bits set in this cycle |
| rd_data | output | 7 | Sticky error log |
| err_pulse | output | 1 | High for the frame period after a faulty frame |
| irq | output | 1 | Interrupt, high while the log is non-empty |
| out_vld | output | 1 | Output sample strobe |
| out_sample | output | SAMPLE_W | Concealed audio sample |

## Verification
Suppose the sticky log drops or gains a bit. The error shows on `rd_data` and `irq` one cycle after the frame that caused it, and it stays there until the next read. That read is used to check the clear-only-what-was-seen rule. A wrong hold register shows nothing until a concealed frame in hold mode, so the tests place a good frame, a faulty frame carrying a different sample, and a second faulty frame in a row. The second faulty frame shows whether the faulty sample leaked into the hold value. A wrong concealment class, for example a CRC fault that conceals, shows on `out_sample` one cycle after that frame.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
    localparam int ERR_N = 7;

    localparam int BIT_UNLOCK   = 0;
    localparam int BIT_VALIDITY = 1;
    localparam int BIT_CONF     = 2;
    localparam int BIT_BIPHASE  = 3;
    localparam int BIT_PARITY   = 4;
    localparam int BIT_QCRC     = 5;
    localparam int BIT_CSCRC    = 6;

    // faults that may corrupt audio (the CRC faults are excluded)
    localparam logic [ERR_N-1:0] CONCEAL_SET = 7'b001_1111;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_MUTE  = 2'b10,
        MODE_PASS2 = 2'b11
    } conceal_mode_e;
endpackage

// File: rtl/rxerr_log.sv
module rxerr_log
    import rxerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [ERR_N-1:0] hit,
    input  logic             rd_stb,
    output logic [ERR_N-1:0] log_bits,
    output logic             pulse,
    output logic             irq
);
    typedef struct packed {
        logic [ERR_N-1:0] log;
        logic             pulse;
        logic             irq;
    } log_state_t;

    log_state_t st_d, st_q;

    always_comb begin
        logic [ERR_N-1:0] keep;
        logic [ERR_N-1:0] new_bits;
        st_d     = st_q;
        keep     = rd_stb ? '0 : st_q.log;
        new_bits = in_vld ? hit : '0;
        st_d.log = keep | new_bits;
        if (in_vld) begin
            st_d.pulse = |hit;
        end
        st_d.irq = |st_d.log;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign log_bits = st_q.log;
    assign pulse    = st_q.pulse;
    assign irq      = st_q.irq;
endmodule

// File: rtl/rxerr_conceal.sv
module rxerr_conceal
    import rxerr_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                bad,
    input  logic [1:0]          mode,
    output logic                out_vld,
    output logic [SAMPLE_W-1:0] out_sample
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] held;
        logic [SAMPLE_W-1:0] smp;
        logic                vld;
    } cc_state_t;

    cc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (!bad) begin
                st_d.held = in_sample;
                st_d.smp  = in_sample;
            end else begin
                unique case (conceal_mode_e'(mode))
                    MODE_HOLD: st_d.smp = st_q.held;
                    MODE_MUTE: st_d.smp = '0;
                    default:   st_d.smp = in_sample;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld    = st_q.vld;
    assign out_sample = st_q.smp;
endmodule

// File: rtl/rxerr_logger.sv
module rxerr_logger
    import rxerr_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [6:0]          in_err,
    input  logic [6:0]          err_en,
    input  logic [1:0]          conceal_mode,
    input  logic                rd_stb,
    output logic [6:0]          rd_data,
    output logic                err_pulse,
    output logic                irq,
    output logic                out_vld,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic [ERR_N-1:0] hit;
    logic             bad;

    assign hit = in_err & err_en;
    assign bad = |(hit & CONCEAL_SET);

    rxerr_log u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .hit      (hit),
        .rd_stb   (rd_stb),
        .log_bits (rd_data),
        .pulse    (err_pulse),
        .irq      (irq)
    );

    rxerr_conceal #(.SAMPLE_W(SAMPLE_W)) u_conceal (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (in_vld),
        .in_sample  (in_sample),
        .bad        (bad),
        .mode       (conceal_mode),
        .out_vld    (out_vld),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/rxerr_logger_chk.sv
module rxerr_logger_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_vld,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [6:0]          in_err,
    input logic [6:0]          err_en,
    input logic [1:0]          conceal_mode,
    input logic                rd_stb,
    input logic [6:0]          rd_data,
    input logic                err_pulse,
    input logic                irq,
    input logic                out_vld,
    input logic [SAMPLE_W-1:0] out_sample
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R2

    AST_NEW_BITS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data & ~($past(rd_stb) ? 7'd0 : $past(rd_data))
                  & ~($past(in_vld) ? $past(in_err & err_en) : 7'd0)) == 7'd0)); // R4

    AST_PULSE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (err_pulse == |$past(in_err & err_en))); // R5

    AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(err_pulse)); // R5

    AST_IRQ_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data != 7'd0)); // R6

    AST_OUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R7

    AST_CRC_NO_CONCEAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_err & err_en & 7'b001_1111) == 7'd0)
        |=> (out_sample == $past(in_sample))); // R11
endmodule

bind rxerr_logger rxerr_logger_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/tb_rxerr_logger.sv
module tb_rxerr_logger;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [6:0]    in_err = '0;
    logic [6:0]    err_en = 7'h7f;
    logic [1:0]    conceal_mode = 2'b00;
    logic          rd_stb = 1'b0;
    logic [6:0]    rd_data;
    logic          err_pulse;
    logic          irq;
    logic          out_vld;
    logic [SW-1:0] out_sample;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxerr_logger #(.SAMPLE_W(SW)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one frame at a falling edge; outputs are sampled one falling edge later
    task automatic frame(input logic [SW-1:0] s, input logic [6:0] e, input logic rd);
        in_vld = 1'b1; in_sample = s; in_err = e; rd_stb = rd;
        @(negedge clk);
        in_vld = 1'b0; in_err = '0; rd_stb = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] exp, input string req);
        chk(req, {25'd0, rd_data}, {25'd0, exp});
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_data", {25'd0, rd_data}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 pulse", {31'd0, err_pulse}, 0);
        chk("R1 out_vld", {31'd0, out_vld}, 0);
    endtask

    task automatic t_hold_and_sticky;
        conceal_mode = 2'b01;
        frame(24'h111111, 7'd0, 1'b0);
        chk("R7 out_vld", {31'd0, out_vld}, 1);
        chk("R10 clean pass", out_sample, 24'h111111);
        frame(24'h222222, 7'b000_0001, 1'b0);
        chk("R8 hold", out_sample, 24'h111111);
        chk("R5 pulse", {31'd0, err_pulse}, 1);
        chk("R2 logged", {25'd0, rd_data}, 7'h01);
        chk("R6 irq", {31'd0, irq}, 1);
        frame(24'h333333, 7'b000_0100, 1'b0);
        chk("R12 held not updated", out_sample, 24'h111111);
        @(negedge clk);
        chk("R7 out_vld drop", {31'd0, out_vld}, 0);
        chk("R5 pulse held", {31'd0, err_pulse}, 1);
        frame(24'h444444, 7'd0, 1'b0);
        chk("R5 pulse clear", {31'd0, err_pulse}, 0);
        chk("R2 sticky", {25'd0, rd_data}, 7'h05);
        do_read(7'h05, "R3 read value");
        chk("R3 cleared", {25'd0, rd_data}, 0);
        chk("R6 irq clear", {31'd0, irq}, 0);
    endtask

    task automatic t_read_collision;
        frame(24'h1, 7'b000_1000, 1'b0);
        frame(24'h2, 7'b001_0000, 1'b1);
        chk("R3 same-cycle kept", {25'd0, rd_data}, 7'h10);
        do_read(7'h10, "R3 second read");
    endtask

    task automatic t_masked;
        conceal_mode = 2'b10;
        err_en = 7'b111_1101;
        frame(24'habcdef, 7'b000_0010, 1'b0);
        chk("R4 not concealed", out_sample, 24'habcdef);
        chk("R4 no pulse", {31'd0, err_pulse}, 0);
        chk("R4 no log", {25'd0, rd_data}, 0);
        chk("R4 no irq", {31'd0, irq}, 0);
        err_en = 7'h7f;
    endtask

    task automatic t_mute_pass_crc;
        conceal_mode = 2'b10;
        frame(24'h123456, 7'b000_1000, 1'b0);
        chk("R9 mute", out_sample, 0);
        frame(24'h654321, 7'b010_0000, 1'b0);
        chk("R11 qcrc no conceal", out_sample, 24'h654321);
        chk("R11 qcrc logged", {25'd0, rd_data}, 7'h28);
        conceal_mode = 2'b01;
        frame(24'h777777, 7'b100_0001, 1'b0);
        chk("R11 crc sample became held", out_sample, 24'h654321);
        conceal_mode = 2'b00;
        frame(24'h0f0f0f, 7'b001_0000, 1'b0);
        chk("R10 pass mode", out_sample, 24'h0f0f0f);
        conceal_mode = 2'b11;
        frame(24'h0a0a0a, 7'b000_0100, 1'b0);
        chk("R10 mode 11 pass", out_sample, 24'h0a0a0a);
        do_read(7'h7d, "R2 accumulated");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hold_and_sticky();
        t_read_collision();
        t_masked();
        t_mute_pass_crc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule